// File: doc/BRIEF.md
# Descriptor List Channel Register Set

This block is the slave register file for a two-channel bus-master audio or modem engine. It has one input (capture) channel and one output (playback) channel. Each channel holds three things. The first is the base address of its descriptor list in memory. The second is the index of the descriptor the engine is working on now. The third is the index of the last descriptor that software has made valid. Software reaches these registers through a 32-bit I/O port with byte lanes, so it can read or write a single byte, or read neighbouring byte registers packed into one wider access.

The current index is read-only to software. Only the DMA engine changes it: the engine sends a one-cycle advance pulse each time it finishes a descriptor. The list holds 16 entries, so the index counts modulo 16. The block gives the engine each channel's list base and current index. It also drives a level flag per channel that is high while the current index equals the last valid index, which tells the engine to stop after the descriptor it is on.

The port is addressed by dword. `reg_addr` carries byte-offset bits 4:2: bit 2 of `reg_addr` picks the channel (0 = input, byte offsets 00h-0Fh; 1 = output, byte offsets 10h-1Fh), and bits 1:0 pick the dword inside the channel. Byte lane k of the data bus is byte offset k within that dword. Read data is combinational.

Top module: `dlist_regs`

## Requirements
- R1: After a synchronous active-low reset, every base address, current index and last valid index is zero, and both at-last flags are high.
- R2: A write at channel dword 0 (byte offset 00h) updates only the base address bytes whose `reg_be` bit is set. Base bits 2:0 always read as zero, so a full write of FFFFFFFFh reads back FFFFFFF8h.
- R3: `reg_addr` bit 2 selects the channel (0 = input, 1 = output). An access to one channel never changes or reads the other channel.
- R4: Each cycle with `advance[c]` high increments channel c's current index by one. The index wraps from 15 to 0, and its bit 4 stays zero.
- R5: The current index is read-only. A software write to byte offset 04h (dword 1, lane 0) has no effect, and the index changes only on an advance pulse.
- R6: A write to dword 1 with lane 1 enabled stores `reg_wdata[12:8]` as the last valid index (byte offset 05h). Bits 7:5 of that byte read as zero.
- R7: A read of dword 1 with all lanes enabled returns {8'h00, status byte 8'h00, last valid index byte, current index byte}. A read with a single lane enabled returns only that byte, and all other lanes are zero.
- R8: Reads of dwords 2 and 3 of either channel return zero, and writes to them change nothing. When `reg_rd` is low, `reg_rdata` is zero.
- R9: `at_last[c]` is high exactly while channel c's current index equals its last valid index.
- R10: An advance pulse and a software write of the last valid index in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Dword address, byte offset bits 4:2 |
| reg_be | input | 4 | Byte lane enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| advance | input | 2 | Per-channel pulse: engine finished a descriptor |
| dma_base | output | 64 | List base per channel (channel 0 in bits 31:0) |
| dma_cur_idx | output | 10 | Current index per channel (channel 0 in bits 4:0) |
| at_last | output | 2 | Per-channel level: current index equals last valid index |

## Verification
The assertions check on every cycle that:
- the current index steps by exactly one, wrapping mod 16, on an advance pulse and holds otherwise;
- the last valid index takes the lane-1 write data and holds without such a write;
- a full base write lands with its low three bits cleared;
- idle and unmapped reads return zero.

Only the bench's scenarios can show the following. They depend on a model of the whole address map and on chosen sequences:
- which channel an address reaches;
- the packed layout of a wide read against single-byte reads;
- that writes at offset 04h are dropped;
- that an advance and a last-index write in the same cycle both land.

// File: rtl/dlist_pkg.sv
// Package dlist_pkg
// Shared sizes and address-slot codes for the descriptor list register set.
// Assumes a 32-bit data bus with four byte lanes and two channels.
package dlist_pkg;
    localparam int NUM_CH   = 2;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int IDX_W    = 5;
    localparam int LIST_LEN = 16;
    localparam int CNT_W    = $clog2(LIST_LEN);
    localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SLOT_W   = 2;
    localparam int ADDR_W   = CH_SEL_W + SLOT_W;

    // Dword slot inside one channel's 16-byte window.
    typedef enum logic [SLOT_W-1:0] {
        SLOT_BASE = 2'd0,
        SLOT_IDX  = 2'd1,
        SLOT_NA2  = 2'd2,
        SLOT_NA3  = 2'd3
    } slot_e;
endpackage

// File: rtl/dlist_chan.sv
// Module dlist_chan
// One channel's registers: list base address, current index, last valid index.
// Assumes write strobes are already decoded for this channel and that the
// advance pulse is one cycle per finished descriptor.
module dlist_chan
    import dlist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_idx,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              advance,
    output logic [DATA_W-1:0] base_q,
    output logic [IDX_W-1:0]  civ_q,
    output logic [IDX_W-1:0]  lvi_q,
    output logic              at_last
);
    localparam int ALIGN_W = 3;

    // Base address: byte-lane writes, low bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) base_q[8*b +: 8] <= wdata[8*b +: 8];
            end
            base_q[ALIGN_W-1:0] <= '0;
        end
    end

    // Current index: hardware-only, modulo-LIST_LEN increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            civ_q <= '0;
        end else if (advance) begin
            civ_q <= {{(IDX_W-CNT_W){1'b0}}, civ_q[CNT_W-1:0] + 1'b1};
        end
    end

    // Last valid index: software writes through lane 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvi_q <= '0;
        end else if (wr_idx && be[1]) begin
            lvi_q <= wdata[8 +: IDX_W];
        end
    end

    // Stop flag for the engine.
    assign at_last = (civ_q == lvi_q);

    assert_civ_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (civ_q[CNT_W-1:0] == $past(civ_q[CNT_W-1:0]) + 1'b1));
    assert_civ_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(civ_q));
    assert_lvi_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx && be[1]) |=> (lvi_q == $past(wdata[8 +: IDX_W])));
    assert_lvi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_idx && be[1]) |=> $stable(lvi_q));
    assert_base_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && be == '1) |=> (base_q == {$past(wdata[DATA_W-1:ALIGN_W]), 3'b000}));
endmodule

// File: rtl/dlist_rdmux.sv
// Module dlist_rdmux
// Builds the combinational read word from all channels' registers and masks
// it per byte lane. Assumes packed per-channel buses, channel 0 lowest.
module dlist_rdmux
    import dlist_pkg::*;
(
    input  logic [ADDR_W-1:0]        sel,
    input  logic [BE_W-1:0]          be,
    input  logic                     rd,
    input  logic [NUM_CH*DATA_W-1:0] bases,
    input  logic [NUM_CH*IDX_W-1:0]  civs,
    input  logic [NUM_CH*IDX_W-1:0]  lvis,
    output logic [DATA_W-1:0]        rdata
);
    logic [CH_SEL_W-1:0] ch;
    slot_e               slot;
    logic [DATA_W-1:0]   word;

    assign ch   = sel[ADDR_W-1 -: CH_SEL_W];
    assign slot = slot_e'(sel[SLOT_W-1:0]);

    // Select the addressed dword; unmapped slots give zero.
    always_comb begin
        word = '0;
        case (slot)
            SLOT_BASE: word = bases[int'(ch)*DATA_W +: DATA_W];
            SLOT_IDX:  word = {8'h00, 8'h00,
                               {(8-IDX_W){1'b0}}, lvis[int'(ch)*IDX_W +: IDX_W],
                               {(8-IDX_W){1'b0}}, civs[int'(ch)*IDX_W +: IDX_W]};
            default:   word = '0;
        endcase
    end

    // Lane masking: only enabled lanes of an active read carry data.
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            rdata[8*b +: 8] = (rd && be[b]) ? word[8*b +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/dlist_regs.sv
// Module dlist_regs
// Two-channel descriptor list register set. Decodes the dword address into
// per-channel write strobes, instantiates one dlist_chan per channel and the
// read mux. Assumes reg_wr and reg_rd are single-cycle qualified strobes.
module dlist_regs
    import dlist_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [BE_W-1:0]          reg_be,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CH-1:0]        advance,
    output logic [NUM_CH*DATA_W-1:0] dma_base,
    output logic [NUM_CH*IDX_W-1:0]  dma_cur_idx,
    output logic [NUM_CH-1:0]        at_last
);
    logic [NUM_CH*IDX_W-1:0] lvi_all;
    logic [SLOT_W-1:0]       slot;

    assign slot = reg_addr[SLOT_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Channel decode from the upper address bits.
        assign hit = (reg_addr[ADDR_W-1 -: CH_SEL_W] == CH_SEL_W'(c));

        dlist_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (reg_wr && hit && slot == SLOT_BASE),
            .wr_idx  (reg_wr && hit && slot == SLOT_IDX),
            .be      (reg_be),
            .wdata   (reg_wdata),
            .advance (advance[c]),
            .base_q  (dma_base[c*DATA_W +: DATA_W]),
            .civ_q   (dma_cur_idx[c*IDX_W +: IDX_W]),
            .lvi_q   (lvi_all[c*IDX_W +: IDX_W]),
            .at_last (at_last[c])
        );
    end

    dlist_rdmux u_rdmux (
        .sel   (reg_addr),
        .be    (reg_be),
        .rd    (reg_rd),
        .bases (dma_base),
        .civs  (dma_cur_idx),
        .lvis  (lvi_all),
        .rdata (reg_rdata)
    );

    assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
    assert_rd_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && slot[1]) |-> (reg_rdata == '0));
endmodule

// File: tb/test_dlist_regs.sv
// Bench for dlist_regs: directed corner cases plus seeded random traffic,
// checked against a bench-side model of the register map.
module test_dlist_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  advance = '0;
    logic [63:0] dma_base;
    logic [9:0]  dma_cur_idx;
    logic [1:0]  at_last;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_base [2];
    logic [4:0]  m_civ  [2];
    logic [4:0]  m_lvi  [2];

    always #5 clk = ~clk;

    dlist_regs i_dlist_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .advance(advance), .dma_base(dma_base),
        .dma_cur_idx(dma_cur_idx), .at_last(at_last)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a, input logic [3:0] be);
        logic [31:0] w;
        logic [31:0] r;
        int c;
        c = int'(a[2]);
        case (a[1:0])
            2'd0:    w = m_base[c];
            2'd1:    w = {16'h0000, 3'b000, m_lvi[c], 3'b000, m_civ[c]};
            default: w = '0;
        endcase
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? w[8*b +: 8] : 8'h00;
        return r;
    endfunction

    task automatic model_update(input logic [2:0] a, input logic [3:0] be,
                                input logic wr, input logic [31:0] wd, input logic [1:0] adv);
        int c;
        c = int'(a[2]);
        if (wr && a[1:0] == 2'd0) begin
            for (int b = 0; b < 4; b++) if (be[b]) m_base[c][8*b +: 8] = wd[8*b +: 8];
            m_base[c][2:0] = 3'b000;
        end
        if (wr && a[1:0] == 2'd1 && be[1]) m_lvi[c] = wd[12:8];
        for (int k = 0; k < 2; k++) if (adv[k]) m_civ[k] = {1'b0, m_civ[k][3:0] + 4'd1};
    endtask

    // One bus cycle: drive at negedge, check combinational read and flags, then
    // update the model at the clock edge the design samples.
    task automatic cyc(input string req, input logic [2:0] a, input logic [3:0] be,
                       input logic wr, input logic rd, input logic [31:0] wd,
                       input logic [1:0] adv);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_wr = wr; reg_rd = rd; reg_wdata = wd; advance = adv;
        #1;
        chk({req, " rdata"}, reg_rdata, rd ? model_read(a, be) : 32'h0);
        chk("R9 at_last", at_last, {m_civ[1] == m_lvi[1], m_civ[0] == m_lvi[0]});
        chk("R4 dma_cur_idx", dma_cur_idx, {m_civ[1], m_civ[0]});
        chk("R2 dma_base", dma_base, {m_base[1], m_base[0]});
        @(posedge clk);
        model_update(a, be, wr, wd, adv);
    endtask

    task automatic rd_cyc(input string req, input logic [2:0] a, input logic [3:0] be);
        cyc(req, a, be, 1'b0, 1'b1, 32'h0, 2'b00);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h0000_5eed);
        for (int c = 0; c < 2; c++) begin m_base[c] = '0; m_civ[c] = '0; m_lvi[c] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk("R1 at_last after reset", at_last, 2'b11);
        rd_cyc("R1 in base", 3'd0, 4'hF);
        rd_cyc("R1 out idx", 3'd5, 4'hF);

        // R2: full and partial base writes
        cyc("R2 full write", 3'd0, 4'hF, 1'b1, 1'b0, 32'hFFFF_FFFF, 2'b00);
        rd_cyc("R2 low bits zero", 3'd0, 4'hF);
        chk("R2 FFFFFFF8", dma_base[31:0], 32'hFFFF_FFF8);
        cyc("R2 byte write", 3'd0, 4'b0100, 1'b1, 1'b0, 32'h0012_3456, 2'b00);
        rd_cyc("R2 partial", 3'd0, 4'hF);
        // R3: output channel untouched by input writes, then written
        rd_cyc("R3 out base untouched", 3'd4, 4'hF);
        cyc("R3 out write", 3'd4, 4'hF, 1'b1, 1'b0, 32'hA5A5_0007, 2'b00);
        rd_cyc("R3 out base", 3'd4, 4'hF);
        rd_cyc("R3 in base kept", 3'd0, 4'hF);

        // R6: lvi write with high bits set
        cyc("R6 lvi write", 3'd1, 4'b0010, 1'b1, 1'b0, 32'h0000_FF00, 2'b00);
        rd_cyc("R6 lvi byte", 3'd1, 4'b0010);
        chk("R6 lvi read", reg_rdata, 32'h0000_1F00);

        // R5: write to current index ignored
        cyc("R5 civ write", 3'd1, 4'b0001, 1'b1, 1'b0, 32'h0000_0009, 2'b00);
        rd_cyc("R5 civ unchanged", 3'd1, 4'b0001);
        chk("R5 civ zero", reg_rdata, 32'h0);

        // R4: 17 advances on input channel wraps to 1
        for (int i = 0; i < 17; i++) cyc("R4 advance", 3'd1, 4'hF, 1'b0, 1'b1, 32'h0, 2'b01);
        rd_cyc("R4 wrap", 3'd1, 4'b0001);
        chk("R4 wrapped to 1", reg_rdata[7:0], 8'h01);

        // R9: set lvi to 3, advance until equal
        cyc("R9 lvi=3", 3'd1, 4'b0010, 1'b1, 1'b0, 32'h0000_0300, 2'b00);
        cyc("R9 adv", 3'd1, 4'h0, 1'b0, 1'b0, 32'h0, 2'b01);
        cyc("R9 adv", 3'd1, 4'h0, 1'b0, 1'b0, 32'h0, 2'b01);
        #1;
        chk("R9 at_last high at 3", at_last[0], 1'b1);

        // R10: advance and lvi write together on output channel
        cyc("R10 same cycle", 3'd5, 4'b0010, 1'b1, 1'b0, 32'h0000_0A00, 2'b10);
        rd_cyc("R10 both land", 3'd5, 4'hF);
        chk("R10 packed", reg_rdata, 32'h0000_0A01);

        // R7: packed vs single-lane reads, status byte zero
        rd_cyc("R7 packed", 3'd1, 4'hF);
        rd_cyc("R7 lane0 only", 3'd1, 4'b0001);
        rd_cyc("R7 status lane", 3'd1, 4'b0100);
        chk("R7 status zero", reg_rdata, 32'h0);

        // R8: unmapped dwords and idle reads
        cyc("R8 unmapped write", 3'd2, 4'hF, 1'b1, 1'b0, 32'hDEAD_BEEF, 2'b00);
        rd_cyc("R8 unmapped read", 3'd6, 4'hF);
        chk("R8 unmapped zero", reg_rdata, 32'h0);
        cyc("R8 idle", 3'd0, 4'hF, 1'b0, 1'b0, 32'h0, 2'b00);

        // Random traffic across all requirements
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  a;
            logic [3:0]  be;
            logic        wr;
            logic [1:0]  adv;
            a   = 3'($urandom_range(0, 7));
            be  = 4'($urandom);
            wr  = ($urandom_range(0, 2) == 0);
            adv = {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
            cyc("R3 random", a, be, wr, !wr, $urandom, adv);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule